// File: doc/BRIEF.md
# Bit-Plane Pipelined FIR Filter

This block is a fully pipelined FIR filter for unsigned samples with unsigned coefficients. It does not use whole-word multipliers. It splits every coefficient into its binary digits and uses one row of the array for each digit of each coefficient. A row picks one delayed input sample, keeps it or zeroes it according to a single coefficient bit, shifts it to that bit's weight, and adds it to the running sum from the row before. It then registers the total. The rows for one bit weight make a plane, and the planes are chained one after another. Each finished sum therefore leaves the last row a fixed number of cycles after its sample entered.

The coefficients come in through a static port. They may only change while no sample is in flight. Samples arrive with a valid strobe, and a sample history advances only on accepted samples. A valid flag travels down the pipe with each partial sum. The output word is wide enough that no input pattern can overflow it. A parameter selects whether the least significant or the most significant plane comes first. This choice moves no result and no cycle.

Top module: `bp_fir_array`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: For any coefficient set, each result equals the sum over t = 0..TAPS-1 of c_t · x(i−t). Both coefficients and samples are unsigned, and x(i−t) is the accepted sample t places before sample i.
- R3: `out_valid` is high exactly TAPS·COEF_W cycles after each cycle in which `in_valid` was sampled high. There is one result per accepted sample and no result otherwise.
- R4: A cycle with `in_valid` low produces no result and does not shift the sample history. A later result therefore skips such cycles when it picks its taps.
- R5: After reset the sample history is empty. Taps that reach back before the first accepted sample count as zero.
- R6: `out_data` is DATA_W + COEF_W + ceil(log2 TAPS) bits wide. All-ones samples with all-ones coefficients give exactly TAPS·(2^COEF_W−1)·(2^DATA_W−1), with no wrap.
- R7: Coefficient c_t sits in `coef_in[t*COEF_W +: COEF_W]`. Coefficient c_0 multiplies the sample accepted in the same cycle.
- R8: The plane-order parameter (low weight first or high weight first) gives the same results with the same latency.
- R9: `out_data` is 0 in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_in | input | TAPS*COEF_W | Packed coefficients, static while samples are in flight |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Unsigned input sample |
| out_valid | output | 1 | Result strobe |
| out_data | output | DATA_W+COEF_W+ceil(log2 TAPS) | Full-precision unsigned result |

## Verification
Each accepted sample's result is due exactly TAPS·COEF_W cycles after the cycle that presented it; with the default configuration that is nine cycles. When the bench drives a sample, it computes the expected sum from its own copy of the sample history. It files that sum in a ring slot indexed by the current cycle plus the latency. On every falling edge it compares both outputs with the slot for that cycle, and an empty slot demands a low strobe and a zero word. Coefficients change only after an idle stretch longer than the latency, so no sum in flight ever mixes two coefficient sets.

// File: rtl/bp_fir_pkg.sv
package bp_fir_pkg;

   // Order in which coefficient bit planes are chained along the pipe.
   typedef enum logic {
      PLANE_LSB_FIRST = 1'b0,
      PLANE_MSB_FIRST = 1'b1
   } plane_order_e;

   // Result width that cannot overflow for unsigned operands.
   function automatic int unsigned acc_width(input int unsigned dw,
                                             input int unsigned cw,
                                             input int unsigned taps);
      return dw + cw + ((taps > 1) ? $clog2(taps) : 0);
   endfunction

endpackage

// File: rtl/bp_tap_window.sv
// Sample history that advances on accepted samples only.
// Slot 0 is the incoming sample itself; slot t is the sample accepted t places earlier.
module bp_tap_window #(
   parameter int unsigned DW   = 4,
   parameter int unsigned TAPS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [DW-1:0]      in_data,
   output logic [TAPS*DW-1:0] taps
);

   assign taps[DW-1:0] = in_data;

   if (TAPS > 1) begin : g_hist
      logic [DW-1:0] hist [0:TAPS-2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < TAPS-1; k++) hist[k] <= '0;
         end else if (in_valid) begin
            hist[0] <= in_data;
            for (int k = 1; k < TAPS-1; k++) hist[k] <= hist[k-1];
         end
      end

      for (genvar k = 1; k < TAPS; k++) begin : g_out
         assign taps[k*DW +: DW] = hist[k-1];
      end
   end

endmodule

// File: rtl/bp_tap_delay.sv
// Free-running delay line for one tap. It brings out only the delays at which
// rows of this tap sit: FIRST, FIRST+STRIDE, ... (COUNT of them).
module bp_tap_delay #(
   parameter int unsigned DW     = 4,
   parameter int unsigned FIRST  = 0,
   parameter int unsigned STRIDE = 3,
   parameter int unsigned COUNT  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DW-1:0]       d,
   output logic [COUNT*DW-1:0] q
);

   localparam int unsigned LAST = FIRST + (COUNT - 1) * STRIDE;

   logic [DW-1:0] chain [0:LAST];

   assign chain[0] = d;

   for (genvar k = 1; k <= LAST; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[k] <= '0;
         else        chain[k] <= chain[k-1];
      end
   end

   for (genvar p = 0; p < COUNT; p++) begin : g_tap
      assign q[p*DW +: DW] = chain[FIRST + p*STRIDE];
   end

endmodule

// File: rtl/bp_plane_row.sv
// One array row: gate a sample by one coefficient bit, weight it, add, register.
module bp_plane_row #(
   parameter int unsigned DW    = 4,
   parameter int unsigned ACC_W = 9,
   parameter int unsigned SHIFT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_in,
   input  logic [ACC_W-1:0] sum_in,
   input  logic [DW-1:0]    x_in,
   input  logic             coef_bit,
   output logic             v_out,
   output logic [ACC_W-1:0] sum_out
);

   logic [ACC_W-1:0] addend;

   assign addend = coef_bit ? (ACC_W'(x_in) << SHIFT) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out   <= 1'b0;
         sum_out <= '0;
      end else begin
         v_out   <= v_in;
         sum_out <= sum_in + addend;
      end
   end

endmodule

// File: rtl/bp_fir_array.sv
module bp_fir_array #(
   parameter int unsigned DATA_W = 4,
   parameter int unsigned COEF_W = 3,
   parameter int unsigned TAPS   = 3,
   parameter bp_fir_pkg::plane_order_e ORDER = bp_fir_pkg::PLANE_LSB_FIRST,
   localparam int unsigned ACC_W = bp_fir_pkg::acc_width(DATA_W, COEF_W, TAPS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TAPS*COEF_W-1:0] coef_in,
   input  logic                   in_valid,
   input  logic [DATA_W-1:0]      in_data,
   output logic                   out_valid,
   output logic [ACC_W-1:0]       out_data
);

   localparam int unsigned STAGES = TAPS * COEF_W;

   // Elaboration-time configuration checks
   if (DATA_W < 1 || COEF_W < 1 || TAPS < 1) begin : g_bad_size
      $error("bp_fir_array: DATA_W, COEF_W and TAPS must all be at least 1");
   end
   if (ACC_W > 64) begin : g_bad_width
      $error("bp_fir_array: result width above 64 bits is not supported");
   end

   logic [TAPS*DATA_W-1:0]   win;
   logic [COEF_W*DATA_W-1:0] tap_x [TAPS];
   logic                     v_q   [0:STAGES];
   logic [ACC_W-1:0]         s_q   [0:STAGES];

   bp_tap_window #(
      .DW   (DATA_W),
      .TAPS (TAPS)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .taps     (win)
   );

   // Each tap is used once per plane, at pipe stages t, t+TAPS, t+2*TAPS, ...
   for (genvar t = 0; t < TAPS; t++) begin : g_tapline
      bp_tap_delay #(
         .DW     (DATA_W),
         .FIRST  (t),
         .STRIDE (TAPS),
         .COUNT  (COEF_W)
      ) u_delay (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (win[t*DATA_W +: DATA_W]),
         .q     (tap_x[t])
      );
   end

   assign v_q[0] = in_valid;
   assign s_q[0] = '0;

   // Plane position p along the pipe, row t inside the plane.
   for (genvar p = 0; p < COEF_W; p++) begin : g_plane
      localparam int unsigned BITW =
         (ORDER == bp_fir_pkg::PLANE_LSB_FIRST) ? p : (COEF_W - 1 - p);

      for (genvar t = 0; t < TAPS; t++) begin : g_row
         localparam int unsigned S = p * TAPS + t;

         bp_plane_row #(
            .DW    (DATA_W),
            .ACC_W (ACC_W),
            .SHIFT (BITW)
         ) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .v_in     (v_q[S]),
            .sum_in   (s_q[S]),
            .x_in     (tap_x[t][p*DATA_W +: DATA_W]),
            .coef_bit (coef_in[t*COEF_W + BITW]),
            .v_out    (v_q[S+1]),
            .sum_out  (s_q[S+1])
         );
      end
   end

   assign out_valid = v_q[STAGES];
   assign out_data  = v_q[STAGES] ? s_q[STAGES] : '0;

endmodule

// File: rtl/bp_fir_checker.sv
module bp_fir_checker #(
   parameter int unsigned DATA_W = 4,
   parameter int unsigned COEF_W = 3,
   parameter int unsigned TAPS   = 3,
   parameter int unsigned ACC_W  = 9
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [TAPS*COEF_W-1:0] coef_in,
   input logic                   in_valid,
   input logic                   out_valid,
   input logic [ACC_W-1:0]       out_data
);

   localparam int unsigned LAT = TAPS * COEF_W;
   localparam longint unsigned PEAK =
      longint'(TAPS) * ((64'd1 << COEF_W) - 64'd1) * ((64'd1 << DATA_W) - 64'd1);

   // Independent record of accepted strobes over the last LAT cycles
   logic [LAT-1:0] vtrack;
   // Number of consecutive recent cycles with every coefficient at zero
   logic [31:0]    zcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vtrack <= '0;
         zcnt   <= '0;
      end else begin
         vtrack <= (vtrack << 1) | LAT'(in_valid);
         if (coef_in != '0)     zcnt <= '0;
         else if (zcnt < LAT)   zcnt <= zcnt + 32'd1;
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vtrack[LAT-1]) else $error("result strobe off its slot"); // R3

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      64'(out_data) <= PEAK) else $error("result above the largest sum"); // R6

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && out_data == '0)) else $error("output not clear after reset"); // R1

   AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
      (zcnt == LAT && out_valid) |-> out_data == '0) else $error("nonzero sum with zero coefficients"); // R2

endmodule

bind bp_fir_array bp_fir_checker #(
   .DATA_W (DATA_W),
   .COEF_W (COEF_W),
   .TAPS   (TAPS),
   .ACC_W  (ACC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .coef_in   (coef_in),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/bp_fir_array_test.sv
module bp_fir_array_test;

   localparam int unsigned DW  = 4;
   localparam int unsigned CW  = 3;
   localparam int unsigned TP  = 3;
   localparam int unsigned LAT = TP * CW;
   localparam int unsigned AW  = DW + CW + $clog2(TP);

   logic          clk;
   logic          rst_n;
   logic [TP*CW-1:0] coef_in;
   logic          in_valid;
   logic [DW-1:0] in_data;
   logic          out_valid, out_valid_m;
   logic [AW-1:0] out_data, out_data_m;

   int  n_checks = 0;
   int  n_errors = 0;
   int  cyc = 0;
   bit  done = 0;
   string dtag = "R2";

   bit          exp_v [64];
   int unsigned exp_d [64];
   int unsigned hist  [TP];

   bp_fir_array #(.DATA_W(DW), .COEF_W(CW), .TAPS(TP),
                  .ORDER(bp_fir_pkg::PLANE_LSB_FIRST)) uut (
      .clk(clk), .rst_n(rst_n), .coef_in(coef_in), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

   bp_fir_array #(.DATA_W(DW), .COEF_W(CW), .TAPS(TP),
                  .ORDER(bp_fir_pkg::PLANE_MSB_FIRST)) uut_msb (
      .clk(clk), .rst_n(rst_n), .coef_in(coef_in), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid_m), .out_data(out_data_m));

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
      end
   endtask

   task automatic clear_model();
      for (int k = 0; k < 64; k++) begin exp_v[k] = 1'b0; exp_d[k] = 0; end
      for (int t = 0; t < TP; t++) hist[t] = 0;
   endtask

   // One cycle: compare the slot due now, then drive the next inputs
   task automatic step(input logic v, input logic [DW-1:0] d);
      int idx;
      int unsigned y;
      @(negedge clk);
      idx = cyc % 64;
      check("R3", out_valid, exp_v[idx]);
      check("R8", out_valid_m, exp_v[idx]);
      if (exp_v[idx]) begin
         check(dtag, out_data, exp_d[idx]);
         check("R8", out_data_m, exp_d[idx]);
      end else begin
         check("R9", out_data, 0);
         check("R9", out_data_m, 0);
      end
      exp_v[idx] = 1'b0;
      in_valid = v;
      in_data  = d;
      if (v && rst_n) begin
         for (int t = TP-1; t > 0; t--) hist[t] = hist[t-1];
         hist[0] = d;
         y = 0;
         for (int t = 0; t < TP; t++) y += int'(coef_in[t*CW +: CW]) * hist[t];
         exp_v[(cyc + LAT) % 64] = 1'b1;
         exp_d[(cyc + LAT) % 64] = y;
      end
      cyc++;
   endtask

   task automatic drain();
      repeat (LAT + 1) step(1'b0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      clear_model();
      @(negedge clk);
      check("R1", out_valid, 0);
      check("R1", out_data, 0);
      check("R1", out_valid_m, 0);
      repeat (2) step(1'b0, '0);
      rst_n = 1'b1;
      step(1'b0, '0);
      check("R1", out_valid, 0);
      check("R1", out_data, 0);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; coef_in = '0;
      clear_model();
      do_reset();

      // R5: taps before the first accepted sample read as zero
      dtag = "R5";
      coef_in = {3'd5, 3'd3, 3'd7};
      step(1'b1, 4'd9); step(1'b1, 4'd2); step(1'b1, 4'd11);
      drain();

      // R7: one nonzero coefficient at each field position
      dtag = "R7";
      for (int t = 0; t < TP; t++) begin
         coef_in = '0;
         coef_in[t*CW +: CW] = 3'd6;
         for (int k = 0; k < 4; k++) step(1'b1, 4'(k + 1));
         drain();
      end

      // R2: every coefficient set, random samples with occasional gaps
      dtag = "R2";
      for (int cs = 0; cs < (1 << (TP*CW)); cs++) begin
         coef_in = (TP*CW)'(cs);
         repeat (6) step(($urandom % 4) != 0, 4'($urandom));
         drain();
      end

      // R4: regular gaps must not shift the history
      dtag = "R4";
      coef_in = {3'd1, 3'd2, 3'd4};
      for (int k = 0; k < 24; k++) step((k % 3) != 1, 4'(k));
      drain();

      // R6: largest operands everywhere
      dtag = "R6";
      coef_in = '1;
      repeat (12) step(1'b1, 4'hF);
      drain();

      // R1 and R5 again: reset in the middle of a stream
      dtag = "R5";
      coef_in = {3'd2, 3'd1, 3'd3};
      repeat (5) step(1'b1, 4'hA);
      do_reset();
      step(1'b1, 4'd6); step(1'b1, 4'd1);
      drain();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule